// File: doc/BRIEF.md
# Segmented Operand Address Unit

This unit forms the memory address of an instruction operand for a 16-bit machine that reaches a 1 MB space through segments. Each request names one of five operand modes and carries a base register value, an index register value, a displacement and a segment value. From these the unit forms a 16-bit offset inside the segment. It then forms a 20-bit physical address by shifting the segment value four places left and adding the offset. Both results are registered and appear on the clock edge that takes the request.

In the same block sits the instruction pointer. When the instruction pointer advances, it moves forward by the length in bytes of the instruction that has just completed. It can also be loaded with a new value. From it and a code segment value the unit forms the physical fetch address of the next instruction. A decoder supplies the mode, the register values and the instruction length. The memory system takes the two physical addresses.

Top module: `seg_agu`

## Requirements
- R1: With mode code 0 (direct), the offset `ea_out` equals the displacement.
- R2: With mode code 1 (register indirect), the offset equals `base_val` when `ind_sel` is 0 and `index_val` when `ind_sel` is 1; the displacement is ignored.
- R3: With mode code 2 (based), the offset is `base_val` plus the displacement. With mode code 3 (indexed), it is `index_val` plus the displacement.
- R4: With mode code 4 (based-indexed), the offset is `base_val` plus `index_val` plus the displacement.
- R5: When `disp_short` is 1, only `disp[7:0]` is used, sign-extended from bit 7 to 16 bits; bits 15:8 have no effect. When `disp_short` is 0, all 16 bits are used.
- R6: The offset sum is kept modulo 2^16, so it wraps inside the segment.
- R7: `pa_out` equals `seg_base` times 16 plus the offset, modulo 2^20 (for example, segment 0100h with offset 0100h gives 01100h).
- R8: Mode codes 5, 6 and 7 give an offset of zero, set `mode_err` to 1 and give `pa_out` equal to `seg_base` times 16. Legal codes clear `mode_err`.
- R9: `ea_out`, `pa_out` and `mode_err` take the new values on the rising edge that samples `req_valid` high, and `out_valid` is high for exactly the cycle after that edge. Without `req_valid` these outputs hold their values.
- R10: On an edge with `ip_step` high, `ip_out` increases by `ip_len` modulo 2^16. `ip_load` takes priority and loads `ip_load_val`. With neither input high, `ip_out` holds. The instruction pointer update is independent of a request handled in the same cycle.
- R11: `fetch_pa` equals `code_seg` times 16 plus `ip_out`, modulo 2^20.
- R12: After reset, `ea_out`, `pa_out`, `mode_err`, `out_valid` and `ip_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operand address request strobe |
| mode | input | 3 | Operand mode code (0 to 4 legal) |
| ind_sel | input | 1 | Register source for the indirect mode: 0 base, 1 index |
| disp_short | input | 1 | Use the sign-extended low byte of the displacement |
| base_val | input | 16 | Base register value |
| index_val | input | 16 | Index register value |
| disp | input | 16 | Displacement from the instruction |
| seg_base | input | 16 | Segment value for the operand |
| code_seg | input | 16 | Segment value for instruction fetch |
| ip_step | input | 1 | Advance the instruction pointer |
| ip_len | input | 4 | Length in bytes of the completed instruction |
| ip_load | input | 1 | Load the instruction pointer |
| ip_load_val | input | 16 | Value to load |
| ea_out | output | 16 | Registered operand offset |
| pa_out | output | 20 | Registered operand physical address |
| mode_err | output | 1 | Registered illegal-mode flag |
| out_valid | output | 1 | Result present, one cycle after the request |
| ip_out | output | 16 | Instruction pointer |
| fetch_pa | output | 20 | Physical address of the next instruction fetch |

## Verification
An operand request and an instruction pointer step can be taken on the same clock edge. Each writes its own registers, and the fetch address is derived from the pointer as it changes. The bench provokes this by raising `req_valid` and `ip_step` in one cycle, and in another cycle by raising `ip_step` and `ip_load` together. It then checks that the operand outputs match a request handled alone, that the pointer has moved by the length only (or taken the loaded value when a load was present), and that `fetch_pa` follows the new pointer value.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

   typedef enum logic [2:0] {
      AM_DIRECT  = 3'd0,
      AM_REGIND  = 3'd1,
      AM_BASED   = 3'd2,
      AM_INDEXED = 3'd3,
      AM_BASEIDX = 3'd4
   } agu_mode_e;

   function automatic logic mode_is_legal(input logic [2:0] code);
      return code <= 3'd4;
   endfunction

endpackage

// File: rtl/seg_agu_offset.sv
module seg_agu_offset
   import seg_agu_pkg::*;
#(
   parameter int OFS_W   = 16,
   parameter int SHORT_W = 8
) (
   input  logic [2:0]       mode,
   input  logic             ind_sel,
   input  logic             disp_short,
   input  logic [OFS_W-1:0] base_val,
   input  logic [OFS_W-1:0] index_val,
   input  logic [OFS_W-1:0] disp,
   output logic [OFS_W-1:0] ea,
   output logic             illegal
);

   localparam int EXT_W = OFS_W - SHORT_W;

   if (SHORT_W < 1 || SHORT_W >= OFS_W) begin : g_bad_short
      $error("seg_agu_offset: SHORT_W must lie between 1 and OFS_W-1");
   end

   logic [OFS_W-1:0] disp_eff;
   logic [OFS_W-1:0] sum_bd;
   logic [OFS_W-1:0] sum_id;
   logic [OFS_W-1:0] sum_bid;

   // short displacement: sign-extend the low byte, upper bits ignored
   always_comb begin
      if (disp_short)
         disp_eff = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
      else
         disp_eff = disp;
   end

   // all sums truncate to OFS_W bits: the offset wraps within the segment
   always_comb begin
      sum_bd  = base_val + disp_eff;
      sum_id  = index_val + disp_eff;
      sum_bid = base_val + index_val + disp_eff;
   end

   always_comb begin
      illegal = !mode_is_legal(mode);
      unique case (mode)
         AM_DIRECT:  ea = disp_eff;
         AM_REGIND:  ea = ind_sel ? index_val : base_val;
         AM_BASED:   ea = sum_bd;
         AM_INDEXED: ea = sum_id;
         AM_BASEIDX: ea = sum_bid;
         default:    ea = '0;
      endcase
   end

endmodule

// File: rtl/seg_agu_phys.sv
module seg_agu_phys #(
   parameter int OFS_W     = 16,
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter bit SPLIT_ADD = 1'b1,
   localparam int PA_W     = SEG_W + SEG_SHIFT
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFS_W-1:0] ofs,
   output logic [PA_W-1:0]  pa
);

   localparam int HI_W = OFS_W - SEG_SHIFT;

   if (SEG_SHIFT < 1 || SEG_SHIFT >= OFS_W) begin : g_bad_shift
      $error("seg_agu_phys: SEG_SHIFT must lie between 1 and OFS_W-1");
   end
   if (HI_W > SEG_W) begin : g_bad_seg
      $error("seg_agu_phys: offset wider than the shifted segment reach");
   end

   if (SPLIT_ADD) begin : g_split
      // low bits of the offset pass straight through; only the upper part adds
      logic [SEG_W-1:0] ofs_hi;
      logic [SEG_W-1:0] sum_hi;
      always_comb begin
         ofs_hi = SEG_W'(ofs[OFS_W-1:SEG_SHIFT]);
         sum_hi = seg + ofs_hi;
         pa     = {sum_hi, ofs[SEG_SHIFT-1:0]};
      end
   end else begin : g_full
      always_comb begin
         pa = {seg, {SEG_SHIFT{1'b0}}} + PA_W'(ofs);
      end
   end

endmodule

// File: rtl/seg_agu_ip.sv
module seg_agu_ip #(
   parameter int               OFS_W    = 16,
   parameter int               LEN_W    = 4,
   parameter logic [OFS_W-1:0] IP_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [LEN_W-1:0] len,
   input  logic             load,
   input  logic [OFS_W-1:0] load_val,
   output logic [OFS_W-1:0] ip
);

   if (LEN_W < 1 || LEN_W > OFS_W) begin : g_bad_len
      $error("seg_agu_ip: LEN_W must lie between 1 and OFS_W");
   end

   logic [OFS_W-1:0] ip_next;

   always_comb begin
      if (load)
         ip_next = load_val;
      else if (step)
         ip_next = ip + OFS_W'(len);
      else
         ip_next = ip;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ip <= IP_RESET;
      else        ip <= ip_next;
   end

endmodule

// File: rtl/seg_agu.sv
module seg_agu #(
   parameter int OFS_W     = 16,
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int SHORT_W   = 8,
   parameter int LEN_W     = 4,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [2:0]                 mode,
   input  logic                       ind_sel,
   input  logic                       disp_short,
   input  logic [OFS_W-1:0]           base_val,
   input  logic [OFS_W-1:0]           index_val,
   input  logic [OFS_W-1:0]           disp,
   input  logic [SEG_W-1:0]           seg_base,
   input  logic [SEG_W-1:0]           code_seg,
   input  logic                       ip_step,
   input  logic [LEN_W-1:0]           ip_len,
   input  logic                       ip_load,
   input  logic [OFS_W-1:0]           ip_load_val,
   output logic [OFS_W-1:0]           ea_out,
   output logic [SEG_W+SEG_SHIFT-1:0] pa_out,
   output logic                       mode_err,
   output logic                       out_valid,
   output logic [OFS_W-1:0]           ip_out,
   output logic [SEG_W+SEG_SHIFT-1:0] fetch_pa
);

   localparam int PA_W = SEG_W + SEG_SHIFT;

   logic [OFS_W-1:0] ea_c;
   logic             illegal_c;
   logic [PA_W-1:0]  pa_c;

   seg_agu_offset #(
      .OFS_W   (OFS_W),
      .SHORT_W (SHORT_W)
   ) u_ofs (
      .mode       (mode),
      .ind_sel    (ind_sel),
      .disp_short (disp_short),
      .base_val   (base_val),
      .index_val  (index_val),
      .disp       (disp),
      .ea         (ea_c),
      .illegal    (illegal_c)
   );

   seg_agu_phys #(
      .OFS_W     (OFS_W),
      .SEG_W     (SEG_W),
      .SEG_SHIFT (SEG_SHIFT),
      .SPLIT_ADD (SPLIT_ADD)
   ) u_opnd_pa (
      .seg (seg_base),
      .ofs (ea_c),
      .pa  (pa_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_out    <= '0;
         pa_out    <= '0;
         mode_err  <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            ea_out   <= ea_c;
            pa_out   <= pa_c;
            mode_err <= illegal_c;
         end
      end
   end

   seg_agu_ip #(
      .OFS_W (OFS_W),
      .LEN_W (LEN_W)
   ) u_ip (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (ip_step),
      .len      (ip_len),
      .load     (ip_load),
      .load_val (ip_load_val),
      .ip       (ip_out)
   );

   seg_agu_phys #(
      .OFS_W     (OFS_W),
      .SEG_W     (SEG_W),
      .SEG_SHIFT (SEG_SHIFT),
      .SPLIT_ADD (SPLIT_ADD)
   ) u_fetch_pa (
      .seg (code_seg),
      .ofs (ip_out),
      .pa  (fetch_pa)
   );

endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk #(
   parameter int OFS_W     = 16,
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int LEN_W     = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       req_valid,
   input logic [SEG_W-1:0]           seg_base,
   input logic [SEG_W-1:0]           code_seg,
   input logic                       ip_step,
   input logic [LEN_W-1:0]           ip_len,
   input logic                       ip_load,
   input logic [OFS_W-1:0]           ip_load_val,
   input logic [OFS_W-1:0]           ea_out,
   input logic [SEG_W+SEG_SHIFT-1:0] pa_out,
   input logic                       mode_err,
   input logic                       out_valid,
   input logic [OFS_W-1:0]           ip_out,
   input logic [SEG_W+SEG_SHIFT-1:0] fetch_pa
);

   localparam int PA_W = SEG_W + SEG_SHIFT;

   logic [PA_W-1:0] fetch_ref;
   assign fetch_ref = {code_seg, {SEG_SHIFT{1'b0}}} + PA_W'(ip_out);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid); // R9
   AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid); // R9
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(ea_out) && $stable(pa_out) && $stable(mode_err))); // R9
   AST_ERR_ZERO_EA: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> (ea_out == '0)); // R8
   AST_ERR_SEG_PA: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid ##1 mode_err) |-> (pa_out == {$past(seg_base), {SEG_SHIFT{1'b0}}})); // R8
   AST_IP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (ip_step && !ip_load) |=> (ip_out == OFS_W'($past(ip_out) + OFS_W'($past(ip_len))))); // R10
   AST_IP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ip_load |=> (ip_out == $past(ip_load_val))); // R10
   AST_IP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ip_step && !ip_load) |=> $stable(ip_out)); // R10
   AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_pa == fetch_ref); // R11

endmodule

bind seg_agu seg_agu_chk #(
   .OFS_W     (OFS_W),
   .SEG_W     (SEG_W),
   .SEG_SHIFT (SEG_SHIFT),
   .LEN_W     (LEN_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .seg_base    (seg_base),
   .code_seg    (code_seg),
   .ip_step     (ip_step),
   .ip_len      (ip_len),
   .ip_load     (ip_load),
   .ip_load_val (ip_load_val),
   .ea_out      (ea_out),
   .pa_out      (pa_out),
   .mode_err    (mode_err),
   .out_valid   (out_valid),
   .ip_out      (ip_out),
   .fetch_pa    (fetch_pa)
);

// File: tb/tb_seg_agu.sv
module tb_seg_agu;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic        ind_sel = 1'b0;
   logic        disp_short = 1'b0;
   logic [15:0] base_val = '0;
   logic [15:0] index_val = '0;
   logic [15:0] disp = '0;
   logic [15:0] seg_base = '0;
   logic [15:0] code_seg = '0;
   logic        ip_step = 1'b0;
   logic [3:0]  ip_len = '0;
   logic        ip_load = 1'b0;
   logic [15:0] ip_load_val = '0;
   logic [15:0] ea_out;
   logic [19:0] pa_out;
   logic        mode_err;
   logic        out_valid;
   logic [15:0] ip_out;
   logic [19:0] fetch_pa;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_agu dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
      .ind_sel(ind_sel), .disp_short(disp_short), .base_val(base_val),
      .index_val(index_val), .disp(disp), .seg_base(seg_base),
      .code_seg(code_seg), .ip_step(ip_step), .ip_len(ip_len),
      .ip_load(ip_load), .ip_load_val(ip_load_val), .ea_out(ea_out),
      .pa_out(pa_out), .mode_err(mode_err), .out_valid(out_valid),
      .ip_out(ip_out), .fetch_pa(fetch_pa)
   );

   // stimulus: {mode, ind_sel, disp_short, base, index, disp, seg}
   localparam logic [68:0] VEC [NVEC] = '{
      {3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h1010, 16'h1200}, // R1
      {3'd1, 1'b0, 1'b0, 16'h0300, 16'h0200, 16'h5555, 16'h2000}, // R2 base
      {3'd1, 1'b1, 1'b0, 16'h0300, 16'h0200, 16'h5555, 16'h2000}, // R2 index
      {3'd2, 1'b0, 1'b0, 16'h1000, 16'h7777, 16'h0034, 16'h3000}, // R3 based
      {3'd3, 1'b0, 1'b0, 16'h7777, 16'h2000, 16'h0F00, 16'h3000}, // R3 indexed
      {3'd4, 1'b0, 1'b0, 16'h1000, 16'h0200, 16'h0010, 16'h0400}, // R4
      {3'd4, 1'b0, 1'b0, 16'hF000, 16'h1000, 16'h0005, 16'h0500}, // R6 wrap
      {3'd2, 1'b0, 1'b1, 16'h0100, 16'h0000, 16'hAAFF, 16'h0600}, // R5 negative
      {3'd3, 1'b0, 1'b1, 16'h0000, 16'h0010, 16'hAB7F, 16'h0600}, // R5 positive
      {3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF}, // R7 wrap
      {3'd5, 1'b0, 1'b0, 16'h1111, 16'h2222, 16'h3333, 16'h1234}, // R8
      {3'd7, 1'b1, 1'b0, 16'h1111, 16'h2222, 16'h3333, 16'h00FF}, // R8
      {3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0100, 16'h0100}  // R7 example
   };

   function automatic logic [15:0] ref_ea(input logic [2:0] m, input logic s,
         input logic sh, input logic [15:0] b, input logic [15:0] x,
         input logic [15:0] d);
      logic [15:0] de;
      de = sh ? {{8{d[7]}}, d[7:0]} : d;
      case (m)
         3'd0: return de;
         3'd1: return s ? x : b;
         3'd2: return 16'(b + de);
         3'd3: return 16'(x + de);
         3'd4: return 16'(b + x + de);
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [19:0] ref_pa(input logic [15:0] sg, input logic [15:0] o);
      return 20'((32'(sg) * 16 + 32'(o)) % 32'h100000);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply_req(input logic [68:0] v);
      @(negedge clk);
      {mode, ind_sel, disp_short, base_val, index_val, disp, seg_base} = v;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] e;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 ea", 32'(ea_out), 32'h0);
      chk("R12 pa", 32'(pa_out), 32'h0);
      chk("R12 err", 32'(mode_err), 32'h0);
      chk("R12 valid", 32'(out_valid), 32'h0);
      chk("R12 ip", 32'(ip_out), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         apply_req(VEC[i]);
         e = ref_ea(VEC[i][68:66], VEC[i][65], VEC[i][64], VEC[i][63:48],
                    VEC[i][47:32], VEC[i][31:16]);
         chk("R1/R2/R3/R4/R5/R6 ea", 32'(ea_out), 32'(e));
         chk("R7 pa", 32'(pa_out), 32'(ref_pa(VEC[i][15:0], e)));
         chk("R8 err", 32'(mode_err), 32'(VEC[i][68:66] > 3'd4));
         chk("R9 valid", 32'(out_valid), 32'h1);
      end

      // R7 worked example stated directly
      chk("R7 01100h", 32'(pa_out), 32'h01100);

      // R9 hold: inputs change without a strobe
      @(negedge clk);
      mode = 3'd4; base_val = 16'h4444; disp = 16'h0001; seg_base = 16'h9999;
      @(negedge clk);
      chk("R9 hold ea", 32'(ea_out), 32'h0100);
      chk("R9 hold pa", 32'(pa_out), 32'h01100);
      chk("R9 no valid", 32'(out_valid), 32'h0);

      // R2 displacement ignored in indirect mode
      apply_req({3'd1, 1'b0, 1'b0, 16'h0ABC, 16'h0000, 16'hFFFF, 16'h0000});
      chk("R2 disp ignored", 32'(ea_out), 32'h0ABC);

      // R10 stepping and R11 fetch address
      code_seg = 16'h0100;
      ip_len = 4'd2; ip_step = 1'b1;
      @(negedge clk);
      ip_step = 1'b0;
      chk("R10 step 2", 32'(ip_out), 32'h0002);
      ip_load = 1'b1; ip_load_val = 16'h0100;
      @(negedge clk);
      ip_load = 1'b0;
      chk("R10 load", 32'(ip_out), 32'h0100);
      chk("R11 fetch", 32'(fetch_pa), 32'h01100);
      ip_load = 1'b1; ip_load_val = 16'hFFFE;
      @(negedge clk);
      ip_load = 1'b0;
      ip_step = 1'b1; ip_len = 4'd3;
      @(negedge clk);
      ip_step = 1'b0;
      chk("R10 wrap", 32'(ip_out), 32'h0001);
      chk("R11 fetch wrap", 32'(fetch_pa), 32'h01001);
      @(negedge clk);
      chk("R10 hold", 32'(ip_out), 32'h0001);

      // R10 load wins over step in the same cycle
      ip_step = 1'b1; ip_len = 4'd5; ip_load = 1'b1; ip_load_val = 16'h2000;
      @(negedge clk);
      ip_step = 1'b0; ip_load = 1'b0;
      chk("R10 load priority", 32'(ip_out), 32'h2000);

      // R10 request and step on the same edge
      {mode, ind_sel, disp_short, base_val, index_val, disp, seg_base} =
         {3'd4, 1'b0, 1'b0, 16'h0011, 16'h0022, 16'h0033, 16'h0F00};
      req_valid = 1'b1; ip_step = 1'b1; ip_len = 4'd4;
      @(negedge clk);
      req_valid = 1'b0; ip_step = 1'b0;
      chk("R10 concurrent ea", 32'(ea_out), 32'h0066);
      chk("R10 concurrent pa", 32'(pa_out), 32'h0F066);
      chk("R10 concurrent ip", 32'(ip_out), 32'h2004);
      chk("R11 concurrent fetch", 32'(fetch_pa), 32'h03004);

      // R12 reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk("R12 re-reset ip", 32'(ip_out), 32'h0);
      chk("R12 re-reset ea", 32'(ea_out), 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule